// File: doc/BRIEF.md
# Frequency Strap Capture and Test-Mode Control

This block samples three frequency-select strap inputs at power-up and turns them into a CPU frequency code for the clock synthesizers. A single input pin serves two purposes. Before the straps are captured, it is an active-low power-good strobe, and the straps are taken while it is low. Once they are captured, the same pin becomes a live power-down request that is active high. The block drives a registered power-down output toward the clock stop logic.

The block also decides whether test mode is active, and what the outputs do in that mode. Test mode can come from a strap: a digital flag reports that the test-select strap sat above its upper threshold at capture time. It can also come from a software control bit. In test mode the outputs are either held at high impedance or driven at the reference divided by N. The captured strap values are presented as read-only readback bits.

The pin is asynchronous, so it passes through a synchronizer of `SYNC_STAGES` flops before it is used. The strap levels are assumed static around the moment of capture and are sampled directly.

Top module: `strap_ctl`

## Requirements
- R1: After reset and until capture, `strap_valid` is 0 and `strap_rb` reads 000. In this state `freq_code` is 0, `freq_reserved` is 0 and `pwr_down` is 0, whatever the straps and the pin level.
- R2: Capture happens when the synchronized pin is first seen low. The outputs show it `SYNC_STAGES`+1 rising edges after the pin falls. `strap_rb` bit 0 holds strap A, bit 1 holds strap B and bit 2 holds strap C, and `strap_valid` becomes 1.
- R3: Once captured, `strap_rb` and the captured test flag do not change with later strap changes or pin activity until reset.
- R4: The strap code {C,B,A} maps to `freq_code` as follows: 101→0 (100 MHz), 001→1 (133), 011→2 (166), 010→3 (200), 000→4 (266), 100→5 (333), 110→6 (400).
- R5: The reserved code 111 gives `freq_code` 0 and `freq_reserved` 1. Every other code, and the state before capture, gives `freq_reserved` 0.
- R6: After capture, `pwr_down` follows the pin with active-high sense, `SYNC_STAGES`+1 edges later. It is never 1 before capture.
- R7: If the test flag was 1 at capture, `test_active` is 1. The captured strap B then selects the test output: B=0 gives `test_hiz`=1, and B=1 gives `test_ref_n`=1.
- R8: `sw_test_en`=1 makes `test_active` 1. Without strap test mode, `sw_test_ref` selects reference/N (1) or Hi-Z (0), and it has no effect while `sw_test_en` is 0.
- R9: When strap test mode is active, strap B decides the test output and `sw_test_ref` is ignored.
- R10: `test_hiz` and `test_ref_n` are never both 1. Both are 0 whenever `test_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| pg_pd_pin | input | 1 | Power-good strobe (low = capture) before capture, power-down request (high) after |
| strap_a | input | 1 | Frequency strap A |
| strap_b | input | 1 | Frequency strap B, also the test output select |
| strap_c | input | 1 | Frequency strap C, also the test-select strap |
| test_thr_hi | input | 1 | Strap C is above the test threshold |
| sw_test_en | input | 1 | Software test-mode entry |
| sw_test_ref | input | 1 | Software test output select (1 = reference/N) |
| strap_valid | output | 1 | Straps have been captured |
| strap_rb | output | 3 | Captured straps {C,B,A}, read-only |
| freq_code | output | 3 | Decoded CPU frequency code |
| freq_reserved | output | 1 | Captured code is the reserved one |
| test_active | output | 1 | Test mode in force |
| test_hiz | output | 1 | Test mode: outputs at Hi-Z |
| test_ref_n | output | 1 | Test mode: outputs at reference/N |
| pwr_down | output | 1 | Power-down toward the clock stop logic |

## Verification
The properties assume the strap levels and the threshold flag are steady during the cycles around capture. They also assume that reset is the only way back to the uncaptured state. The stimulus sets the straps and the flag while the pin is still high. It holds them for several cycles after the pin falls, and it changes them only after capture to show that they are frozen. The software control bits change only on falling clock edges, apart from any strap activity.

// File: rtl/strap_ctl.sv
module strap_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_pd_pin,
  input  logic       strap_a,
  input  logic       strap_b,
  input  logic       strap_c,
  input  logic       test_thr_hi,
  input  logic       sw_test_en,
  input  logic       sw_test_ref,
  output logic       strap_valid,
  output logic [2:0] strap_rb,
  output logic [2:0] freq_code,
  output logic       freq_reserved,
  output logic       test_active,
  output logic       test_hiz,
  output logic       test_ref_n,
  output logic       pwr_down
);

  localparam logic [2:0] F100 = 3'd0;
  localparam logic [2:0] F133 = 3'd1;
  localparam logic [2:0] F166 = 3'd2;
  localparam logic [2:0] F200 = 3'd3;
  localparam logic [2:0] F266 = 3'd4;
  localparam logic [2:0] F333 = 3'd5;
  localparam logic [2:0] F400 = 3'd6;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic                   got_q;
  logic [2:0]             fs_q;
  logic                   tsel_q;
  logic                   pd_q;
  logic                   strap_test;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pg_pd_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q  <= 1'b0;
      fs_q   <= 3'b000;
      tsel_q <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      if (!got_q && !pin_s) begin
        got_q  <= 1'b1;
        fs_q   <= {strap_c, strap_b, strap_a};
        tsel_q <= test_thr_hi;
      end
      pd_q <= got_q & pin_s;
    end
  end

  always_comb begin
    freq_reserved = 1'b0;
    case (fs_q)
      3'b101:  freq_code = F100;
      3'b001:  freq_code = F133;
      3'b011:  freq_code = F166;
      3'b010:  freq_code = F200;
      3'b000:  freq_code = F266;
      3'b100:  freq_code = F333;
      3'b110:  freq_code = F400;
      default: begin
        freq_code     = F100;
        freq_reserved = 1'b1;
      end
    endcase
    if (!got_q) begin
      freq_code     = F100;
      freq_reserved = 1'b0;
    end
  end

  assign strap_valid = got_q;
  assign strap_rb    = fs_q;
  assign pwr_down    = pd_q;
  assign strap_test  = got_q & tsel_q;
  assign test_active = strap_test | sw_test_en;
  assign test_ref_n  = strap_test ? fs_q[1] : (sw_test_en & sw_test_ref);
  assign test_hiz    = test_active & ~test_ref_n;

endmodule

// File: rtl/strap_ctl_chk.sv
module strap_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strap_valid,
  input logic [2:0] strap_rb,
  input logic [2:0] freq_code,
  input logic       freq_reserved,
  input logic       test_active,
  input logic       test_hiz,
  input logic       test_ref_n,
  input logic       pwr_down
);

  a_r1_blank_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_valid |-> (strap_rb == 3'b000 && !freq_reserved && freq_code == 3'd0));

  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    strap_valid |=> strap_valid);

  a_r3_rb_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strap_valid |=> $stable(strap_rb));

  a_r5_reserved_safe: assert property (@(posedge clk) disable iff (!rst_n)
    freq_reserved |-> (freq_code == 3'd0 && strap_rb == 3'b111));

  a_r6_pd_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> strap_valid);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_hiz && test_ref_n));

  a_r10_idle_outside_test: assert property (@(posedge clk) disable iff (!rst_n)
    !test_active |-> (!test_hiz && !test_ref_n));

endmodule

bind strap_ctl strap_ctl_chk u_chk (.*);

// File: tb/sim_strap_ctl.sv
module sim_strap_ctl;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg_pd_pin = 1'b1;
  logic strap_a = 1'b0, strap_b = 1'b0, strap_c = 1'b0;
  logic test_thr_hi = 1'b0, sw_test_en = 1'b0, sw_test_ref = 1'b0;
  logic       strap_valid, freq_reserved, test_active, test_hiz, test_ref_n, pwr_down;
  logic [2:0] strap_rb, freq_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  strap_ctl u0 (
    .clk(clk), .rst_n(rst_n), .pg_pd_pin(pg_pd_pin),
    .strap_a(strap_a), .strap_b(strap_b), .strap_c(strap_c),
    .test_thr_hi(test_thr_hi), .sw_test_en(sw_test_en), .sw_test_ref(sw_test_ref),
    .strap_valid(strap_valid), .strap_rb(strap_rb), .freq_code(freq_code),
    .freq_reserved(freq_reserved), .test_active(test_active), .test_hiz(test_hiz),
    .test_ref_n(test_ref_n), .pwr_down(pwr_down)
  );

  function automatic logic [2:0] ref_code(input logic [2:0] s);
    case (s)
      3'b101: return 3'd0;
      3'b001: return 3'd1;
      3'b011: return 3'd2;
      3'b010: return 3'd3;
      3'b000: return 3'd4;
      3'b100: return 3'd5;
      3'b110: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [11:0] pack(input logic v, input logic [2:0] rb, input logic [2:0] fc,
                                       input logic rs, input logic ta, input logic hz,
                                       input logic rn, input logic pd);
    return {v, rb, fc, rs, ta, hz, rn, pd};
  endfunction

  task automatic expect_now(input string tag, input logic [11:0] e);
    tag_q.push_back(tag);
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [11:0] e;
      logic [11:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {strap_valid, strap_rb, freq_code, freq_reserved, test_active, test_hiz, test_ref_n, pwr_down};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pg_pd_pin = 1'b1;
    sw_test_en = 1'b0;
    sw_test_ref = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic capture(input logic [2:0] s, input logic hi);
    {strap_c, strap_b, strap_a} = s;
    test_thr_hi = hi;
    idle(2);
    pg_pd_pin = 1'b0;
    idle(5);
  endtask

  initial begin
    do_reset();
    {strap_c, strap_b, strap_a} = 3'b101;
    idle(4);
    expect_now("R1 reset state with strobe high", pack(0, 3'b000, 3'd0, 0, 0, 0, 0, 0));
    idle(2);

    capture(3'b101, 1'b0);
    expect_now("R2 capture of 101", pack(1, 3'b101, 3'd0, 0, 0, 0, 0, 0));
    idle(2);

    {strap_c, strap_b, strap_a} = 3'b111;
    test_thr_hi = 1'b1;
    idle(4);
    expect_now("R3 later strap change ignored", pack(1, 3'b101, 3'd0, 0, 0, 0, 0, 0));
    idle(2);

    pg_pd_pin = 1'b1;
    idle(4);
    expect_now("R6 power down follows pin high", pack(1, 3'b101, 3'd0, 0, 0, 0, 0, 1));
    idle(2);
    pg_pd_pin = 1'b0;
    idle(4);
    expect_now("R6 power down released / R3 still frozen", pack(1, 3'b101, 3'd0, 0, 0, 0, 0, 0));
    idle(2);

    sw_test_ref = 1'b1;
    idle(1);
    expect_now("R8 sw_test_ref ignored while sw_test_en low", pack(1, 3'b101, 3'd0, 0, 0, 0, 0, 0));
    idle(1);
    sw_test_en = 1'b1;
    sw_test_ref = 1'b0;
    idle(1);
    expect_now("R8 software test Hi-Z", pack(1, 3'b101, 3'd0, 0, 1, 1, 0, 0));
    idle(1);
    sw_test_ref = 1'b1;
    idle(1);
    expect_now("R8 software test REF/N", pack(1, 3'b101, 3'd0, 0, 1, 0, 1, 0));
    idle(1);
    sw_test_en = 1'b0;
    idle(1);
    expect_now("R10 test outputs idle outside test", pack(1, 3'b101, 3'd0, 0, 0, 0, 0, 0));
    idle(2);

    for (int i = 0; i < 8; i++) begin
      logic [2:0] s;
      s = 3'(i);
      do_reset();
      capture(s, 1'b0);
      if (s == 3'b111)
        expect_now("R5 reserved code safe default", pack(1, s, 3'd0, 1, 0, 0, 0, 0));
      else
        expect_now("R4 decode of strap code", pack(1, s, ref_code(s), 0, 0, 0, 0, 0));
      idle(2);
    end

    do_reset();
    capture(3'b101, 1'b1);
    expect_now("R7 strap test mode with B=0 gives Hi-Z", pack(1, 3'b101, 3'd0, 0, 1, 1, 0, 0));
    idle(2);

    do_reset();
    capture(3'b110, 1'b1);
    expect_now("R7 strap test mode with B=1 gives REF/N", pack(1, 3'b110, 3'd6, 0, 1, 0, 1, 0));
    idle(1);
    sw_test_en = 1'b1;
    sw_test_ref = 1'b0;
    idle(1);
    expect_now("R9 strap select overrides software", pack(1, 3'b110, 3'd6, 0, 1, 0, 1, 0));
    idle(1);
    pg_pd_pin = 1'b1;
    idle(4);
    expect_now("R6 power down in test mode", pack(1, 3'b110, 3'd6, 0, 1, 0, 1, 1));
    idle(2);

    do_reset();
    {strap_c, strap_b, strap_a} = 3'b010;
    pg_pd_pin = 1'b1;
    idle(8);
    expect_now("R1 no capture while strobe stays high", pack(0, 3'b000, 3'd0, 0, 0, 0, 0, 0));
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule